// File: doc/BRIEF.md
# Instruction-Fetch Bus Request Controller

This block sits between an instruction cache and a shared processor bus. It turns fetch demands from the cache into bus requests. A demand carries a word address, a line length of four or eight words, a cacheable flag, a user attribute bit and a two-bit priority. The block raises a single request line together with registered copies of those fields. It waits for the bus slave to take the address, and it records every accepted fetch in a small in-order queue. It counts read-data beats against the queue head so that it can report when each fetch has finished.

The cache keeps `fetch_valid` high until it sees `fetch_accept`. In the cycle after the accept it either drops `fetch_valid` or presents the next demand, which is a prefetch. Asserting `fetch_cancel` while the bus request is high withdraws a request that has not been accepted. The block allows at most two accepted fetches to be in flight. It leaves the request line low for at least one cycle between requests. When the queue is full, a further request waits until the oldest fetch has delivered its final beat.

Top module: `ifetch_req_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `bus_req`, `bus_abort`, `fetch_accept` and `fetch_done` are all low.
- R2: If `fetch_valid` is high in a cycle where no request is pending and fewer than two fetches are outstanding, `bus_req` is high in the next cycle. `bus_addr`, `bus_cacheable`, `bus_attr` and `bus_prio` then carry the values that were presented.
- R3: While `bus_req` is high, `bus_size` is 2'b01 for a four-word line and 2'b10 for an eight-word line. No other code is ever driven.
- R4: Once raised, `bus_req` stays high with stable fields until the slave acknowledges or the request is aborted. `fetch_accept` is high in the acknowledge cycle. `bus_req` is low in the next cycle, and `bus_addr` still holds the accepted address in that cycle.
- R5: After any acknowledge or abort, `bus_req` is low for at least one cycle, even if `fetch_valid` stays high.
- R6: A second request (a prefetch) may be raised once the first has been accepted. While two accepted fetches are outstanding, `bus_req` stays low.
- R7: With two fetches outstanding, a waiting request rises no earlier than two cycles after the last read-data beat of the oldest fetch.
- R8: `fetch_cancel` during a pending, unaccepted request drives `bus_abort` high in that cycle and drops `bus_req` in the next. The aborted fetch never enters the queue.
- R9: If `fetch_cancel` and `bus_addr_ack` are high in the same request cycle, the abort is ignored: `bus_abort` stays low and the fetch is accepted.
- R10: `fetch_done` pulses with the 4th beat of a four-word fetch and with the 8th beat of an eight-word fetch. Fetches complete in the order they were accepted.
- R11: `bus_rd_ack` while no fetch is outstanding is ignored and does not advance beat counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Cache demands a fetch |
| fetch_addr | input | AW | Word address of the demand |
| fetch_line8 | input | 1 | 1: eight-word line, 0: four-word line |
| fetch_cacheable | input | 1 | Cacheable flag of the demand |
| fetch_attr | input | 1 | User attribute bit of the demand |
| fetch_prio | input | PRW | Priority of the demand |
| fetch_cancel | input | 1 | Cache withdraws the pending request |
| fetch_accept | output | 1 | Pending request was acknowledged this cycle |
| fetch_done | output | 1 | Oldest fetch received its final beat this cycle |
| bus_req | output | 1 | Bus request line |
| bus_addr | output | AW | Word address of the request |
| bus_size | output | 2 | Line-size code |
| bus_cacheable | output | 1 | Cacheable flag of the request |
| bus_attr | output | 1 | User attribute of the request |
| bus_prio | output | PRW | Request priority for the bus arbiter |
| bus_abort | output | 1 | Request withdrawn this cycle |
| bus_addr_ack | input | 1 | Slave acknowledges the address |
| bus_rd_ack | input | 1 | Slave returns one read-data beat |

## Verification
The bench builds the block with a 12-bit word address, two-bit priority, a queue depth of two and line lengths of four and eight beats. The small address makes no difference to the control logic, and the default depth and line lengths keep the beat counts small. These values let the bench sweep every combination of line size, priority, cacheable flag and acknowledge delay from zero to two cycles. The same configuration reaches the full-queue stall, the two-cycle release after the last beat, an abort alone and an abort coinciding with an acknowledge, and beats that arrive with nothing outstanding.

// File: rtl/ifr_pkg.sv
// Shared constants and helpers for the instruction-fetch request controller.
// Assumes exactly two line lengths exist: a short and a long one.
package ifr_pkg;

    localparam logic [1:0] SIZE_SHORT = 2'b01;
    localparam logic [1:0] SIZE_LONG  = 2'b10;

    // Map the long-line flag to the bus size code.
    function automatic logic [1:0] size_code(input logic long_line);
        return long_line ? SIZE_LONG : SIZE_SHORT;
    endfunction

endpackage

// File: rtl/ifr_issue.sv
// Request issue stage: holds the bus request line and the registered
// request fields. It assumes the caller raises `raise` only while no request
// is pending. An acknowledge takes precedence over an abort in the same cycle.
module ifr_issue #(
    parameter int AW  = 30,
    parameter int PRW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           raise,
    input  logic [AW-1:0]  in_addr,
    input  logic           in_line8,
    input  logic           in_cacheable,
    input  logic           in_attr,
    input  logic [PRW-1:0] in_prio,
    input  logic           cancel,
    input  logic           addr_ack,
    output logic           req,
    output logic [AW-1:0]  addr,
    output logic           line8,
    output logic           cacheable,
    output logic           attr,
    output logic [PRW-1:0] prio,
    output logic           taken,
    output logic           withdrawn
);
    logic req_q;

    // Outcome of the pending request in this cycle.
    always_comb begin
        taken     = req_q & addr_ack;
        withdrawn = req_q & cancel & ~addr_ack;
    end

    // Request line: set on raise, cleared by acknowledge or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (raise)
            req_q <= 1'b1;
        else if (taken || withdrawn)
            req_q <= 1'b0;
    end

    // Field capture: fields are loaded at raise and held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            line8     <= 1'b0;
            cacheable <= 1'b0;
            attr      <= 1'b0;
            prio      <= '0;
        end else if (raise) begin
            addr      <= in_addr;
            line8     <= in_line8;
            cacheable <= in_cacheable;
            attr      <= in_attr;
            prio      <= in_prio;
        end
    end

    assign req = req_q;

endmodule

// File: rtl/ifr_queue.sv
// In-order queue of accepted fetches with a beat counter for the head entry.
// Each entry keeps only its line length. The head retires on its final beat.
// Assumes push is never raised while the queue is full.
// Beats that arrive while the queue is empty are ignored.
module ifr_queue #(
    parameter int DEPTH       = 2,
    parameter int SHORT_BEATS = 4,
    parameter int LONG_BEATS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       push_line8,
    input  logic                       rd_ack,
    output logic [$clog2(DEPTH+1)-1:0] occ,
    output logic                       done
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int BW   = (LONG_BEATS > 1) ? $clog2(LONG_BEATS) : 1;
    localparam logic [BW-1:0] LAST_SHORT = BW'(SHORT_BEATS - 1);
    localparam logic [BW-1:0] LAST_LONG  = BW'(LONG_BEATS - 1);
    localparam logic [PTRW-1:0] PTR_TOP  = PTRW'(DEPTH - 1);

    logic [DEPTH-1:0] long_q;
    logic [PTRW-1:0]  wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic [BW-1:0]    beat_q;
    logic             head_last, beat_ok, pop;

    // Beat qualification and head retirement.
    always_comb begin
        beat_ok   = rd_ack && (cnt_q != '0);
        head_last = (beat_q == (long_q[rd_q] ? LAST_LONG : LAST_SHORT));
        pop       = beat_ok && head_last;
    end

    // Per-entry line length storage, one register per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                long_q[g] <= 1'b0;
            else if (push && (wr_q == PTRW'(g)))
                long_q[g] <= push_line8;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push)
                wr_q <= (wr_q == PTR_TOP) ? '0 : wr_q + 1'b1;
            if (pop)
                rd_q <= (rd_q == PTR_TOP) ? '0 : rd_q + 1'b1;
            if (push && !pop)
                cnt_q <= cnt_q + 1'b1;
            else if (pop && !push)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Beat counter for the head entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= '0;
        else if (beat_ok)
            beat_q <= head_last ? '0 : beat_q + 1'b1;
    end

    assign occ  = cnt_q;
    assign done = pop;

endmodule

// File: rtl/ifetch_req_ctrl.sv
// Instruction-fetch bus request controller. It issues one request at a time,
// keeps up to DEPTH accepted fetches in order and reports each completion.
// The registered request line gives the idle cycle between requests.
// Because occupancy is registered, a full queue also enforces the two-cycle
// release after the oldest fetch's final beat.
module ifetch_req_ctrl #(
    parameter int AW          = 30,
    parameter int PRW         = 2,
    parameter int DEPTH       = 2,
    parameter int SHORT_BEATS = 4,
    parameter int LONG_BEATS  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fetch_valid,
    input  logic [AW-1:0]  fetch_addr,
    input  logic           fetch_line8,
    input  logic           fetch_cacheable,
    input  logic           fetch_attr,
    input  logic [PRW-1:0] fetch_prio,
    input  logic           fetch_cancel,
    output logic           fetch_accept,
    output logic           fetch_done,
    output logic           bus_req,
    output logic [AW-1:0]  bus_addr,
    output logic [1:0]     bus_size,
    output logic           bus_cacheable,
    output logic           bus_attr,
    output logic [PRW-1:0] bus_prio,
    output logic           bus_abort,
    input  logic           bus_addr_ack,
    input  logic           bus_rd_ack
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] occ;
    logic          raise, line8, taken, withdrawn;

    // Issue decision: idle request line, a demand, and room in the queue.
    always_comb raise = fetch_valid && !bus_req && (occ < FULL);

    ifr_issue #(.AW(AW), .PRW(PRW)) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .raise        (raise),
        .in_addr      (fetch_addr),
        .in_line8     (fetch_line8),
        .in_cacheable (fetch_cacheable),
        .in_attr      (fetch_attr),
        .in_prio      (fetch_prio),
        .cancel       (fetch_cancel),
        .addr_ack     (bus_addr_ack),
        .req          (bus_req),
        .addr         (bus_addr),
        .line8        (line8),
        .cacheable    (bus_cacheable),
        .attr         (bus_attr),
        .prio         (bus_prio),
        .taken        (taken),
        .withdrawn    (withdrawn)
    );

    ifr_queue #(
        .DEPTH       (DEPTH),
        .SHORT_BEATS (SHORT_BEATS),
        .LONG_BEATS  (LONG_BEATS)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (taken),
        .push_line8 (line8),
        .rd_ack     (bus_rd_ack),
        .occ        (occ),
        .done       (fetch_done)
    );

    // Output decode of size code and handshake pulses.
    always_comb begin
        bus_size     = ifr_pkg::size_code(line8);
        fetch_accept = taken;
        bus_abort    = withdrawn;
    end

endmodule

// File: rtl/ifr_chk.sv
// Protocol checker for the instruction-fetch request controller.
// It is attached to every instance of the top module through bind.
module ifr_chk #(
    parameter int AW    = 30,
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_req,
    input logic [AW-1:0]              bus_addr,
    input logic [1:0]                 bus_size,
    input logic                       bus_addr_ack,
    input logic                       bus_abort,
    input logic                       fetch_done,
    input logic [$clog2(DEPTH+1)-1:0] occ
);
    // R3
    size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_size == 2'b01 || bus_size == 2'b10));

    // R4
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_addr_ack && !bus_abort) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_size)));

    // R4
    drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr_ack) |=> (!bus_req && $stable(bus_addr)));

    // R8
    drop_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort |=> !bus_req);

    // R9
    ack_beats_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr_ack) |-> !bus_abort);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (occ < ($clog2(DEPTH+1))'(DEPTH)));

    // R7
    third_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && occ == ($clog2(DEPTH+1))'(DEPTH)) |=> !bus_req);

endmodule

bind ifetch_req_ctrl ifr_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_addr_ack (bus_addr_ack),
    .bus_abort    (bus_abort),
    .fetch_done   (fetch_done),
    .occ          (occ)
);

// File: tb/ifetch_req_ctrl_test.sv
module ifetch_req_ctrl_test;
    localparam int AW  = 12;
    localparam int PRW = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           fetch_valid, fetch_line8, fetch_cacheable, fetch_attr, fetch_cancel;
    logic [AW-1:0]  fetch_addr;
    logic [PRW-1:0] fetch_prio;
    logic           bus_addr_ack, bus_rd_ack;
    logic           fetch_accept, fetch_done, bus_req, bus_cacheable, bus_attr, bus_abort;
    logic [AW-1:0]  bus_addr;
    logic [1:0]     bus_size;
    logic [PRW-1:0] bus_prio;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ifetch_req_ctrl #(.AW(AW), .PRW(PRW), .DEPTH(2), .SHORT_BEATS(4), .LONG_BEATS(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_line8(fetch_line8),
        .fetch_cacheable(fetch_cacheable), .fetch_attr(fetch_attr), .fetch_prio(fetch_prio),
        .fetch_cancel(fetch_cancel), .fetch_accept(fetch_accept), .fetch_done(fetch_done),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_cacheable(bus_cacheable), .bus_attr(bus_attr), .bus_prio(bus_prio),
        .bus_abort(bus_abort), .bus_addr_ack(bus_addr_ack), .bus_rd_ack(bus_rd_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Present a demand and check the raised request one edge later.
    task automatic present(input int a, input bit l8, input bit ca, input bit at, input int pr);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = AW'(a); fetch_line8 = l8;
        fetch_cacheable = ca; fetch_attr = at; fetch_prio = PRW'(pr);
        @(negedge clk);
        chk(bus_req == 1'b1, "R2", "req raised", bus_req, 1);
        chk(bus_addr == AW'(a), "R2", "addr", bus_addr, a);
        chk(bus_cacheable == ca && bus_attr == at, "R2", "cacheable/attr",
            {bus_cacheable, bus_attr}, {ca, at});
        chk(bus_prio == PRW'(pr), "R2", "prio", bus_prio, pr);
        chk(bus_size == (l8 ? 2'b10 : 2'b01), "R3", "size code", bus_size, l8 ? 2 : 1);
    endtask

    // Acknowledge after dly cycles, then drop the demand.
    task automatic accept(input int dly, input int a);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk(bus_req == 1'b1 && bus_addr == AW'(a), "R4", "held until ack",
                bus_req, 1);
        end
        bus_addr_ack = 1'b1;
        #1 chk(fetch_accept == 1'b1, "R4", "accept pulse", fetch_accept, 1);
        @(negedge clk);
        bus_addr_ack = 1'b0; fetch_valid = 1'b0;
        chk(bus_req == 1'b0, "R4", "req drops after ack", bus_req, 0);
        chk(bus_addr == AW'(a), "R4", "addr valid after ack", bus_addr, a);
    endtask

    // Deliver n beats back to back; done expected at beat d1 and d2 (1-based, 0 none).
    task automatic beats(input int n, input int d1, input int d2, input string req);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            bus_rd_ack = 1'b1;
            #1 chk(fetch_done == (i == d1 || i == d2), req, $sformatf("done at beat %0d", i),
                   fetch_done, (i == d1 || i == d2));
        end
        @(negedge clk);
        bus_rd_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog all actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        fetch_valid = 0; fetch_addr = '0; fetch_line8 = 0; fetch_cacheable = 0;
        fetch_attr = 0; fetch_prio = '0; fetch_cancel = 0;
        bus_addr_ack = 0; bus_rd_ack = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_req == 0 && bus_abort == 0, "R1", "req/abort in reset", {bus_req, bus_abort}, 0);
        chk(fetch_accept == 0 && fetch_done == 0, "R1", "accept/done in reset",
            {fetch_accept, fetch_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req == 0, "R1", "req after reset", bus_req, 0);

        // Sweep of size, priority, flags and ack delay (R2, R3, R4, R10).
        for (int l8 = 0; l8 < 2; l8++)
            for (int pr = 0; pr < 4; pr++)
                for (int ca = 0; ca < 2; ca++)
                    for (int d = 0; d < 3; d++) begin
                        int a;
                        a = (l8 * 1031 + pr * 257 + ca * 97 + d * 13 + 5) % 4096;
                        present(a, l8[0], ca[0], ca[0] ^ pr[0], pr);
                        accept(d, a);
                        beats(l8 ? 8 : 4, l8 ? 8 : 4, 0, "R10");
                    end

        // Prefetch, full queue, release timing and ordering (R5, R6, R7, R10).
        present(12'h100, 1'b0, 1'b1, 1'b0, 2);
        bus_addr_ack = 1'b1;
        fetch_addr = 12'h200; fetch_line8 = 1'b1; fetch_prio = 2'd1;
        @(negedge clk);
        bus_addr_ack = 1'b0;
        chk(bus_req == 0, "R5", "gap after ack with demand held", bus_req, 0);
        chk(bus_addr == 12'h100, "R4", "addr held in gap", bus_addr, 12'h100);
        @(negedge clk);
        chk(bus_req == 1 && bus_addr == 12'h200, "R6", "prefetch raised", bus_req, 1);
        chk(bus_size == 2'b10, "R3", "prefetch size", bus_size, 2);
        bus_addr_ack = 1'b1;
        fetch_addr = 12'h300; fetch_line8 = 1'b0;
        @(negedge clk);
        bus_addr_ack = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(bus_req == 0, "R6", "no third request while full", bus_req, 0);
        end
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            bus_rd_ack = 1'b1;
            #1 chk(fetch_done == (i == 4), "R10", "head done on 4th", fetch_done, i == 4);
            chk(bus_req == 0, "R7", "held during head beats", bus_req, 0);
        end
        @(negedge clk);
        bus_rd_ack = 1'b0;
        chk(bus_req == 0, "R7", "low one cycle after last beat", bus_req, 0);
        @(negedge clk);
        chk(bus_req == 1 && bus_addr == 12'h300, "R7", "raised two cycles after last beat",
            bus_req, 1);
        accept(0, 12'h300);
        beats(8, 8, 0, "R10");
        beats(4, 4, 0, "R10");

        // Abort of a pending request (R8, R5).
        present(12'h0A5, 1'b0, 1'b0, 1'b1, 3);
        fetch_cancel = 1'b1;
        #1 chk(bus_abort == 1 && fetch_accept == 0, "R8", "abort driven",
               {bus_abort, fetch_accept}, 2);
        @(negedge clk);
        fetch_cancel = 1'b0;
        fetch_addr = 12'h0B6; fetch_line8 = 1'b1;
        chk(bus_req == 0, "R8", "req drops after abort", bus_req, 0);
        @(negedge clk);
        chk(bus_req == 1 && bus_addr == 12'h0B6, "R5", "new req after one idle cycle",
            bus_req, 1);
        accept(0, 12'h0B6);
        beats(8, 8, 0, "R8");

        // Abort coinciding with acknowledge (R9).
        present(12'h0C7, 1'b0, 1'b1, 1'b1, 0);
        fetch_cancel = 1'b1; bus_addr_ack = 1'b1;
        #1 chk(bus_abort == 0 && fetch_accept == 1, "R9", "ack wins over abort",
               {bus_abort, fetch_accept}, 1);
        @(negedge clk);
        fetch_cancel = 1'b0; bus_addr_ack = 1'b0; fetch_valid = 1'b0;
        chk(bus_req == 0, "R9", "req drops", bus_req, 0);
        beats(4, 4, 0, "R9");

        // Stray beats with nothing outstanding (R11).
        beats(3, 0, 0, "R11");
        present(12'h0D8, 1'b0, 1'b0, 1'b0, 1);
        accept(1, 12'h0D8);
        beats(4, 4, 0, "R11");

        finished = 1;
        summary();
        $finish;
    end
endmodule